// File: doc/BRIEF.md
# Timing-Error Correcting Register

A bank of storage bits that captures its data input on a main strobe and then, on a later check strobe, compares the still-settling input against what was stored. Any bit whose input changed in between is flagged. Its output is inverted in place, so the next logic stage sees the late value without the producing stage having to recompute. One fast clock drives the block. The main and check strobes are each high for one fast-clock cycle, main first, so together they model a pulsed capture followed by a delayed pulse.

The per-bit flags are ORed into a single register error output, which a stall controller can watch. The flags can be cleared in one of two ways, chosen by a parameter. For a shallow next stage, the next main strobe clears every flag whenever any flag is set. For a deep next stage, the flags persist until the stall controller pulses an explicit clear input.

Top module: `tecr_reg`

## Requirements
- R1: While rst_ni is low, every stored bit and every flag is 0, so q_o, flag_o and err_o are all 0.
- R2: A clock edge with main_stb_i high loads d_i into the stored value. Without main_stb_i, the stored value is held whatever d_i does.
- R3: A clock edge with chk_stb_i high (and no clear) sets flag_o[i] to 1 exactly when d_i[i] differs from stored bit i, and to 0 otherwise. A flag never becomes 1 on any other edge.
- R4: q_o[i] equals stored bit i XOR flag_o[i]. Unflagged bits pass through unchanged, and any number of bits can be inverted in the same cycle.
- R5: err_o is 1 exactly when at least one bit of flag_o is 1.
- R6: With MODE = CLR_SHALLOW, a flag stays set until the next main_stb_i edge, and that edge clears all flags. clr_i has no effect in this mode.
- R7: With MODE = CLR_DEEP, main_stb_i does not clear flags. An edge with clr_i high clears all flags, and this clear takes priority over a check capture on the same edge.
- R8: Asserting rst_ni low at any time clears the state at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| main_stb_i | input | 1 | Main capture strobe, one cycle |
| chk_stb_i | input | 1 | Delayed check strobe, one cycle, after main |
| clr_i | input | 1 | Flag clear from the stall controller (deep mode only) |
| d_i | input | WIDTH | Data from the preceding logic stage |
| q_o | output | WIDTH | Corrected data to the following stage |
| flag_o | output | WIDTH | Per-bit correction flags |
| err_o | output | 1 | OR of all flags |

## Verification
A wrong stored bit shows up on q_o one edge after the main strobe that should have loaded it. A flag that is set wrongly, or that fails to set, flips the matching q_o bit and err_o on the edge after the check strobe. A flag that is not cleared keeps a q_o bit inverted past the next main strobe in shallow mode, or past the clear edge in deep mode. That faulty data is visible within one cycle of the strobe that should have reset it. Injecting late data on one bit, on all bits, and on a scattered pair makes a fault in the per-bit comparison or in the inversion visible as a wrong value on q_o.

// File: rtl/tecr_pkg.sv
package tecr_pkg;
  typedef enum logic {
    CLR_SHALLOW = 1'b0,
    CLR_DEEP    = 1'b1
  } clr_mode_e;
endpackage

// File: rtl/tecr_cell.sv
module tecr_cell (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic main_stb_i,
  input  logic chk_stb_i,
  input  logic clr_i,
  input  logic d_i,
  output logic q_o,
  output logic flag_o
);
  logic stored_q;
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         stored_q <= 1'b0;
    else if (main_stb_i) stored_q <= d_i;
  end

  // clear wins over a capture on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        flag_q <= 1'b0;
    else if (clr_i)     flag_q <= 1'b0;
    else if (chk_stb_i) flag_q <= d_i ^ stored_q;
  end

  assign q_o    = stored_q ^ flag_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/tecr_clr.sv
module tecr_clr
  import tecr_pkg::*;
#(
  parameter clr_mode_e MODE = CLR_SHALLOW
) (
  input  logic main_stb_i,
  input  logic err_i,
  input  logic clr_i,
  output logic clr_o
);
  logic shallow_clr;
  assign shallow_clr = main_stb_i & err_i;
  assign clr_o = (MODE == CLR_DEEP) ? clr_i : shallow_clr;
endmodule

// File: rtl/tecr_reg.sv
module tecr_reg
  import tecr_pkg::*;
#(
  parameter int        WIDTH = 8,
  parameter clr_mode_e MODE  = CLR_SHALLOW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             main_stb_i,
  input  logic             chk_stb_i,
  input  logic             clr_i,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [WIDTH-1:0] flag_o,
  output logic             err_o
);
  logic clr_all;

  tecr_clr #(.MODE(MODE)) u_clr (
    .main_stb_i(main_stb_i),
    .err_i     (err_o),
    .clr_i     (clr_i),
    .clr_o     (clr_all)
  );

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    tecr_cell u_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .main_stb_i(main_stb_i),
      .chk_stb_i (chk_stb_i),
      .clr_i     (clr_all),
      .d_i       (d_i[i]),
      .q_o       (q_o[i]),
      .flag_o    (flag_o[i])
    );
  end

  assign err_o = |flag_o;
endmodule

// File: rtl/tecr_reg_chk.sv
module tecr_reg_chk
  import tecr_pkg::*;
#(
  parameter int        WIDTH = 8,
  parameter clr_mode_e MODE  = CLR_SHALLOW
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             main_stb_i,
  input logic             chk_stb_i,
  input logic             clr_i,
  input logic [WIDTH-1:0] d_i,
  input logic [WIDTH-1:0] q_o,
  input logic [WIDTH-1:0] flag_o,
  input logic             err_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk_i)
    !rst_ni |-> (q_o == '0 && flag_o == '0 && err_o == 1'b0));

  // R3
  flag_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((flag_o & ~$past(flag_o)) != '0) |-> $past(chk_stb_i));

  // R5
  err_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(chk_stb_i));

  // R2
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!main_stb_i && !chk_stb_i && !clr_i) |=> ($stable(q_o) && $stable(flag_o)));

  // R6
  shallow_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == CLR_SHALLOW && main_stb_i && err_o) |=> (flag_o == '0));

  // R7
  deep_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == CLR_DEEP && clr_i) |=> (flag_o == '0));

  // R7
  deep_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (MODE == CLR_DEEP && main_stb_i && !chk_stb_i && !clr_i) |=> $stable(flag_o));

  // R4
  d_unused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!main_stb_i && !chk_stb_i && $changed(d_i)) |=> $stable(q_o));
endmodule

bind tecr_reg tecr_reg_chk #(.WIDTH(WIDTH), .MODE(MODE)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .main_stb_i(main_stb_i),
  .chk_stb_i (chk_stb_i),
  .clr_i     (clr_i),
  .d_i       (d_i),
  .q_o       (q_o),
  .flag_o    (flag_o),
  .err_o     (err_o)
);

// File: tb/sim_tecr_reg.sv
module sim_tecr_reg;
  import tecr_pkg::*;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       main_stb_i = 1'b0;
  logic       chk_stb_i = 1'b0;
  logic       clr_i = 1'b0;
  logic [7:0] d_i = '0;
  logic [7:0] q0, f0, q1, f1;
  logic       e0, e1;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #10 clk_i = ~clk_i;

  tecr_reg #(.WIDTH(8), .MODE(CLR_SHALLOW)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .main_stb_i(main_stb_i), .chk_stb_i(chk_stb_i),
    .clr_i(clr_i), .d_i(d_i), .q_o(q0), .flag_o(f0), .err_o(e0));

  tecr_reg #(.WIDTH(8), .MODE(CLR_DEEP)) u1 (
    .clk_i(clk_i), .rst_ni(rst_ni), .main_stb_i(main_stb_i), .chk_stb_i(chk_stb_i),
    .clr_i(clr_i), .d_i(d_i), .q_o(q1), .flag_o(f1), .err_o(e1));

  // {main, chk, clr, d, exp_q, exp_flag, exp_err} for the shallow instance
  localparam int NV = 15;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1,1'b0,1'b0,8'hA5,8'hA5,8'h00,1'b0},
    {1'b0,1'b1,1'b0,8'hA5,8'hA5,8'h00,1'b0},
    {1'b0,1'b0,1'b0,8'hA5,8'hA5,8'h00,1'b0},
    {1'b1,1'b0,1'b0,8'h3C,8'h3C,8'h00,1'b0},
    {1'b0,1'b1,1'b0,8'h3D,8'h3D,8'h01,1'b1},  // one late bit
    {1'b0,1'b0,1'b0,8'h00,8'h3D,8'h01,1'b1},  // d outside window ignored
    {1'b1,1'b0,1'b0,8'hF0,8'hF0,8'h00,1'b0},  // main strobe clears
    {1'b0,1'b1,1'b0,8'h0F,8'h0F,8'hFF,1'b1},  // every bit late
    {1'b1,1'b0,1'b0,8'h0F,8'h0F,8'h00,1'b0},
    {1'b0,1'b1,1'b0,8'h0F,8'h0F,8'h00,1'b0},
    {1'b1,1'b0,1'b0,8'h81,8'h81,8'h00,1'b0},
    {1'b0,1'b1,1'b0,8'hC3,8'hC3,8'h42,1'b1},  // two scattered bits
    {1'b0,1'b0,1'b1,8'hC3,8'hC3,8'h42,1'b1},  // clr ignored in shallow
    {1'b1,1'b0,1'b0,8'h55,8'h55,8'h00,1'b0},
    {1'b0,1'b0,1'b0,8'hAA,8'h55,8'h00,1'b0}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic c, input logic k, input logic [7:0] d);
    @(negedge clk_i);
    main_stb_i = m; chk_stb_i = c; clr_i = k; d_i = d;
    @(posedge clk_i);
    #5;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (2) @(posedge clk_i);
    #5;
    check("R1 q", q0, 8'h00);
    check("R1 flag", f0, 8'h00);
    check("R1 err", {7'b0, e0}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][27], VEC[i][26], VEC[i][25], VEC[i][24:17]);
      check($sformatf("R2/R4 q vec%0d", i), q0, VEC[i][16:9]);
      check($sformatf("R3/R6 flag vec%0d", i), f0, VEC[i][8:1]);
      check($sformatf("R5 err vec%0d", i), {7'b0, e0}, {7'b0, VEC[i][0]});
    end

    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;

    step(1'b1, 1'b0, 1'b0, 8'h12);
    check("R2 deep q", q1, 8'h12);
    step(1'b0, 1'b1, 1'b0, 8'h16);
    check("R3 deep flag", f1, 8'h04);
    check("R4 deep q", q1, 8'h16);
    check("R5 deep err", {7'b0, e1}, 8'h01);
    step(1'b1, 1'b0, 1'b0, 8'h20);
    check("R7 deep flag kept", f1, 8'h04);
    check("R7 deep q", q1, 8'h24);
    check("R6 shallow q", q0, 8'h20);
    check("R6 shallow flag", f0, 8'h00);
    step(1'b0, 1'b0, 1'b1, 8'h20);
    check("R7 clr flag", f1, 8'h00);
    check("R7 clr q", q1, 8'h20);
    check("R7 clr err", {7'b0, e1}, 8'h00);
    step(1'b0, 1'b1, 1'b1, 8'hFF);
    check("R7 clr priority flag", f1, 8'h00);
    check("R7 clr priority q", q1, 8'h20);
    step(1'b0, 1'b1, 1'b0, 8'h01);
    check("R3 deep setup flag", f1, 8'h21);
    check("R4 deep setup q", q1, 8'h01);

    @(negedge clk_i);
    main_stb_i = 1'b0; chk_stb_i = 1'b0; clr_i = 1'b0;
    #3;
    rst_ni = 1'b0;
    #2;
    check("R8 async q", q1, 8'h00);
    check("R8 async flag", f1, 8'h00);
    check("R8 async err", {7'b0, e1}, 8'h00);
    @(negedge clk_i);
    rst_ni = 1'b1;

    finish_run();
  end
endmodule